// File: doc/BRIEF.md
# Threshold-Pruned Add-Compare-Select Unit

This block is the metric core of an adaptive hard-decision trellis decoder for a rate-1/2 code with four states. Every accepted stage it takes one 2-bit received symbol, forms a Hamming branch metric for each of the eight trellis transitions, and runs add-compare-select into each of the four states. It then prunes the trellis. A state survives only if its new cost is below the bound set by the previous stage's best cost plus a threshold that is supplied on the same stage.

Symbols arrive as an unsegmented stream with a per-stage strobe. The block keeps 8-bit saturating path metrics. Each stage it shifts them down by the new minimum, so the best survivor always sits at zero and the threshold bound reduces to a compare against the threshold alone. A downstream survivor memory consumes the per-state decision bits and the alive mask. The stage minimum and the best state index are also given, and a monitor can use the minimum as a running channel-quality figure.

Top module: `prune_acs`

## Requirements
- R1: After reset, state 0 is the only live state: alive_o = 4'b0001, dec_o = 0, min_metric_o = 0, best_state_o = 0, out_valid_o = 0. State 0 starts at metric 0.
- R2: Branch outputs: a state s = {s1,s0} with input bit m goes to state {s0,m} and produces the symbol {m^s1^s0, m^s0}. The branch metric is the number of bit positions where that symbol differs from sym_i, which is 0 to 2.
- R3: For state n = {n1,n0}, the two predecessors are {0,n1} (decision 0) and {1,n1} (decision 1), both with input bit n0. The survivor is the predecessor with the smaller metric plus branch metric. On a tie the decision is 0.
- R4: A dead predecessor takes no part in the compare. A state with no live predecessor becomes dead. dec_o reads 0 for every state that is dead after the stage.
- R5: A state with a live predecessor stays alive only if its winning sum is strictly less than thresh_i. The sum is measured relative to the previous stage's minimum, which is 0.
- R6: The best state is the live state with the lowest sum, with the lowest index on a tie. It is always kept alive, even when thresh_i would prune it, so at least one state is always live.
- R7: min_metric_o is the new stage minimum measured relative to the previous stage's minimum, which is 0 to 2. Every surviving metric is reduced by this amount.
- R8: All outputs update one clock after a cycle with sym_valid_i high and hold otherwise. out_valid_o is high exactly one clock after each accepted symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sym_valid_i | input | 1 | Accept sym_i this cycle as one trellis stage |
| sym_i | input | 2 | Received hard-decision symbol, bit 1 then bit 0 |
| thresh_i | input | 4 | Pruning threshold for this stage |
| dec_o | output | 4 | Per-state decision bit, bit n for state n |
| alive_o | output | 4 | Per-state survivor mask |
| min_metric_o | output | 8 | Stage minimum, relative to the previous stage |
| best_state_o | output | 2 | Index of the best state |
| out_valid_o | output | 1 | Outputs refreshed from the last accepted symbol |

## Verification
On every cycle the assertions check that the best state is in the alive mask and that the mask is never empty. They also check that dead states report a zero decision, that the stage minimum grows by at most 2, and that out_valid_o follows the strobe by one clock. The exact decision bits, the effect of the threshold on each mask, tie handling and the held outputs between strobes can only be shown by the bench's scenarios. Those compare against a reference trellis over every threshold value and long symbol streams.

// File: rtl/prune_acs_pkg.sv
package prune_acs_pkg;
  localparam int NS  = 4;
  localparam int SW  = 2;
  localparam int BMW = 2;

  // encoder output for state s and input bit m
  function automatic logic [1:0] branch_sym(input logic [SW-1:0] s, input logic m);
    return {m ^ s[1] ^ s[0], m ^ s[0]};
  endfunction

  function automatic logic [BMW-1:0] ham2(input logic [1:0] a, input logic [1:0] b);
    logic [1:0] x;
    x = a ^ b;
    return BMW'(x[0]) + BMW'(x[1]);
  endfunction
endpackage

// File: rtl/prune_acs_bmu.sv
module prune_acs_bmu
  import prune_acs_pkg::*;
(
  input  logic [1:0]                   sym_i,
  output logic [NS-1:0][1:0][BMW-1:0]  bm_o
);
  for (genvar n = 0; n < NS; n++) begin : g_state
    for (genvar j = 0; j < 2; j++) begin : g_pred
      localparam logic [SW-1:0] PRED = SW'((j << 1) | (n >> 1));
      localparam logic          MBIT = 1'(n & 1);
      assign bm_o[n][j] = ham2(sym_i, branch_sym(PRED, MBIT));
    end
  end
endmodule

// File: rtl/prune_acs_node.sv
module prune_acs_node
  import prune_acs_pkg::*;
#(
  parameter int MW = 8
) (
  input  logic [MW-1:0]  pm_a_i,
  input  logic [MW-1:0]  pm_b_i,
  input  logic           live_a_i,
  input  logic           live_b_i,
  input  logic [BMW-1:0] bm_a_i,
  input  logic [BMW-1:0] bm_b_i,
  output logic [MW-1:0]  sum_o,
  output logic           live_o,
  output logic           dec_o
);
  localparam logic [MW-1:0] MAXV = '1;

  logic [MW:0]   ext_a, ext_b;
  logic [MW-1:0] sat_a, sat_b;

  assign ext_a = {1'b0, pm_a_i} + (MW+1)'(bm_a_i);
  assign ext_b = {1'b0, pm_b_i} + (MW+1)'(bm_b_i);
  assign sat_a = ext_a[MW] ? MAXV : ext_a[MW-1:0];
  assign sat_b = ext_b[MW] ? MAXV : ext_b[MW-1:0];

  always_comb begin
    live_o = live_a_i | live_b_i;
    dec_o  = 1'b0;
    sum_o  = MAXV;
    if (live_a_i && (!live_b_i || sat_a <= sat_b)) begin
      sum_o = sat_a;
    end else if (live_b_i) begin
      sum_o = sat_b;
      dec_o = 1'b1;
    end
  end
endmodule

// File: rtl/prune_acs_select.sv
module prune_acs_select
  import prune_acs_pkg::*;
#(
  parameter int MW = 8,
  parameter int TW = 4
) (
  input  logic [NS-1:0][MW-1:0] sum_i,
  input  logic [NS-1:0]         live_i,
  input  logic [TW-1:0]         thresh_i,
  output logic [NS-1:0]         keep_o,
  output logic [NS-1:0][MW-1:0] next_pm_o,
  output logic [MW-1:0]         min_o,
  output logic [SW-1:0]         best_o
);
  localparam logic [MW-1:0] MAXV = '1;

  logic found;

  always_comb begin
    min_o  = MAXV;
    best_o = '0;
    found  = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (live_i[i] && (!found || sum_i[i] < min_o)) begin
        min_o  = sum_i[i];
        best_o = SW'(i);
        found  = 1'b1;
      end
    end
  end

  // bound is previous minimum (normalized to 0) plus threshold
  for (genvar i = 0; i < NS; i++) begin : g_keep
    assign keep_o[i] = live_i[i] &&
                       ((sum_i[i] < MW'(thresh_i)) || (best_o == SW'(i)));
    assign next_pm_o[i] = keep_o[i] ? (sum_i[i] - min_o) : MAXV;
  end
endmodule

// File: rtl/prune_acs.sv
module prune_acs
  import prune_acs_pkg::*;
#(
  parameter int MW = 8,
  parameter int TW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sym_valid_i,
  input  logic [1:0]      sym_i,
  input  logic [TW-1:0]   thresh_i,
  output logic [NS-1:0]   dec_o,
  output logic [NS-1:0]   alive_o,
  output logic [MW-1:0]   min_metric_o,
  output logic [SW-1:0]   best_state_o,
  output logic            out_valid_o
);
  localparam logic [MW-1:0] MAXV = '1;

  logic [NS-1:0][MW-1:0]        pm_q;
  logic [NS-1:0]                alive_q;
  logic [NS-1:0][1:0][BMW-1:0]  bm;
  logic [NS-1:0][MW-1:0]        sum, next_pm;
  logic [NS-1:0]                live, dec, keep;
  logic [MW-1:0]                stage_min;
  logic [SW-1:0]                stage_best;

  prune_acs_bmu u_bmu (
    .sym_i (sym_i),
    .bm_o  (bm)
  );

  for (genvar n = 0; n < NS; n++) begin : g_acs
    localparam int PA = n >> 1;
    localparam int PB = 2 | (n >> 1);
    prune_acs_node #(.MW(MW)) u_node (
      .pm_a_i   (pm_q[PA]),
      .pm_b_i   (pm_q[PB]),
      .live_a_i (alive_q[PA]),
      .live_b_i (alive_q[PB]),
      .bm_a_i   (bm[n][0]),
      .bm_b_i   (bm[n][1]),
      .sum_o    (sum[n]),
      .live_o   (live[n]),
      .dec_o    (dec[n])
    );
  end

  prune_acs_select #(.MW(MW), .TW(TW)) u_sel (
    .sum_i     (sum),
    .live_i    (live),
    .thresh_i  (thresh_i),
    .keep_o    (keep),
    .next_pm_o (next_pm),
    .min_o     (stage_min),
    .best_o    (stage_best)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NS; i++) pm_q[i] <= (i == 0) ? '0 : MAXV;
      alive_q      <= NS'(1);
      dec_o        <= '0;
      min_metric_o <= '0;
      best_state_o <= '0;
      out_valid_o  <= 1'b0;
    end else begin
      out_valid_o <= sym_valid_i;
      if (sym_valid_i) begin
        pm_q         <= next_pm;
        alive_q      <= keep;
        dec_o        <= dec & keep;
        min_metric_o <= stage_min;
        best_state_o <= stage_best;
      end
    end
  end

  assign alive_o = alive_q;
endmodule

// File: rtl/prune_acs_chk.sv
module prune_acs_chk #(
  parameter int MW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sym_valid_i,
  input logic [3:0]    dec_o,
  input logic [3:0]    alive_o,
  input logic [MW-1:0] min_metric_o,
  input logic [1:0]    best_state_o,
  input logic          out_valid_o
);
  // R6
  best_alive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alive_o[best_state_o]);

  // R6
  never_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alive_o != 4'b0000);

  // R4
  dead_dec_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_o & ~alive_o) == 4'b0000);

  // R7
  min_growth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (min_metric_o <= MW'(2)));

  // R8
  valid_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_valid_i |=> out_valid_o);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_valid_i |=> (!out_valid_o && $stable(alive_o) && $stable(dec_o) &&
                      $stable(min_metric_o) && $stable(best_state_o)));
endmodule

bind prune_acs prune_acs_chk #(.MW(MW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sym_valid_i  (sym_valid_i),
  .dec_o        (dec_o),
  .alive_o      (alive_o),
  .min_metric_o (min_metric_o),
  .best_state_o (best_state_o),
  .out_valid_o  (out_valid_o)
);

// File: tb/tb_prune_acs.sv
`timescale 1ns/1ps
module tb_prune_acs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vld = 1'b0;
  logic [1:0] sym = '0;
  logic [3:0] th = '0;
  logic [3:0] dec_o, alive_o;
  logic [7:0] min_metric_o;
  logic [1:0] best_state_o;
  logic       out_valid_o;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // expected encoder output V1V0, index = state*2 + input
  int exp_tab [8] = '{0, 3, 3, 0, 2, 1, 1, 2};
  int mpm [4];
  bit malive [4];
  int e_dec, e_alive, e_min, e_best;
  logic [7:0] lfsr = 8'hA5;

  always #2.5 clk = ~clk;

  prune_acs dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .sym_valid_i  (vld),
    .sym_i        (sym),
    .thresh_i     (th),
    .dec_o        (dec_o),
    .alive_o      (alive_o),
    .min_metric_o (min_metric_o),
    .best_state_o (best_state_o),
    .out_valid_o  (out_valid_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input int s, input int t);
    int sm [4];
    bit lp [4];
    int win [4];
    int mn;
    int bi;
    bit fnd;
    for (int n = 0; n < 4; n++) begin
      lp[n] = 0; sm[n] = 0; win[n] = 0;
      for (int j = 0; j < 2; j++) begin
        int p, e, d, c;
        p = j * 2 + n / 2;
        e = exp_tab[p * 2 + (n % 2)] ^ s;
        d = (e & 1) + (e >> 1);
        if (malive[p]) begin
          c = mpm[p] + d;
          if (!lp[n] || c < sm[n]) begin
            sm[n] = c; win[n] = j; lp[n] = 1;
          end
        end
      end
    end
    mn = 0; bi = 0; fnd = 0;
    for (int n = 0; n < 4; n++)
      if (lp[n] && (!fnd || sm[n] < mn)) begin mn = sm[n]; bi = n; fnd = 1; end
    e_dec = 0; e_alive = 0;
    for (int n = 0; n < 4; n++) begin
      bit k;
      k = lp[n] && (sm[n] < t || n == bi);
      malive[n] = k;
      mpm[n] = k ? sm[n] - mn : 255;
      if (k) begin
        e_alive |= (1 << n);
        e_dec |= (win[n] << n);
      end
    end
    e_min = mn; e_best = bi;
  endtask

  task automatic do_reset();
    vld = 0;
    rst_n = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    mpm = '{0, 255, 255, 255};
    malive = '{1, 0, 0, 0};
    e_dec = 0; e_alive = 1; e_min = 0; e_best = 0;
    @(negedge clk);
  endtask

  // entered at a negedge; leaves at the next negedge with outputs checked
  task automatic step(input logic [1:0] s, input logic [3:0] t);
    sym = s; th = t; vld = 1;
    model(s, t);
    @(negedge clk);
    chk("R3/R4 decisions", dec_o, e_dec);
    chk("R5 alive mask", alive_o, e_alive);
    chk("R7 stage minimum", min_metric_o, e_min);
    chk("R6 best state", best_state_o, e_best);
    chk("R8 out_valid", out_valid_o, 1);
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] v);
    return {v[6:0], v[7] ^ v[5] ^ v[4] ^ v[3]};
  endfunction

  initial begin
    int rmin [4];
    int rbest [4];
    rmin = '{0, 1, 1, 0};
    rbest = '{0, 0, 0, 1};

    do_reset();
    // R1 reset state
    chk("R1 alive", alive_o, 1);
    chk("R1 dec", dec_o, 0);
    chk("R1 min", min_metric_o, 0);
    chk("R1 best", best_state_o, 0);
    chk("R1 out_valid", out_valid_o, 0);

    // R2 first stage from reset, each symbol, literal expectations
    for (int s = 0; s < 4; s++) begin
      do_reset();
      step(2'(s), 4'd15);
      vld = 0;
      chk("R2 alive after first stage", alive_o, 3);
      chk("R2 first-stage minimum", min_metric_o, rmin[s]);
      chk("R2 first-stage best", best_state_o, rbest[s]);
      // R4 states 2,3 have no live predecessor
      chk("R4 unreached states dead", alive_o[3:2], 0);
      chk("R4 dead decisions zero", dec_o, 0);
      @(negedge clk);
    end

    // R3 wide threshold, every ordered pair of symbols
    do_reset();
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        step(2'(a), 4'd15);
        step(2'(b), 4'd15);
      end
    vld = 0;
    @(negedge clk);

    // R5 sweep of all thresholds over pseudo-random streams
    for (int t = 0; t < 16; t++) begin
      do_reset();
      for (int k = 0; k < 40; k++) begin
        lfsr = nxt(lfsr);
        step(lfsr[1:0], 4'(t));
        // R6 zero threshold keeps only the best state
        if (t == 0) chk("R6 single survivor at T=0", $countones(alive_o), 1);
      end
      vld = 0;
      @(negedge clk);
    end

    // R5 threshold varying per stage
    do_reset();
    for (int k = 0; k < 60; k++) begin
      lfsr = nxt(lfsr);
      step(lfsr[1:0], lfsr[5:2]);
    end

    // R8 outputs hold while strobe is low
    vld = 0;
    sym = ~sym;
    th = 4'd7;
    repeat (3) @(negedge clk);
    chk("R8 hold dec", dec_o, e_dec);
    chk("R8 hold alive", alive_o, e_alive);
    chk("R8 hold min", min_metric_o, e_min);
    chk("R8 hold best", best_state_o, e_best);
    chk("R8 out_valid low", out_valid_o, 0);
    step(2'b01, 4'd3);
    vld = 0;
    @(negedge clk);

    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule